// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Guard

This block sits between the command issuer of an SDRAM controller and the memory command pins of a device with two internal banks. The issuer presents one command at a time as active-low pins, plus a bank select, a precharge-all bit and a clock-enable drop flag, and keeps the request valid. The guard passes the command to the memory pins and raises `req_ready` only in a cycle where every spacing rule holds. Otherwise the pins show a deselect and the issuer keeps the same request until it is accepted.

Each bank keeps a state (idle, open, closing) and a saturating count of the cycles since its last activate or precharge. One further counter measures the time since the most recent activate on either bank. All timing limits are cycle counts given as parameters: a time in nanoseconds divided by the clock period and rounded up. Each bank also has a warning flag that rises as its open time nears the maximum and a violation flag for when the maximum is reached. Commands that make no sense for the current bank state are refused on an error output and are never granted.

Top module: `sdr_timing_guard`

## Requirements
- R1: Commands are decoded from {ras_n,cas_n,we_n} with cs_n low: 011 activate, 101 read, 100 write, 010 precharge, 000 mode-register set, 001 refresh, 110 burst stop, 111 no-operation. cs_n high is a deselect. No-operation, deselect and burst stop are granted in any cycle.
- R2: A read or write to an open bank is granted only once at least TRCD cycles have elapsed since that bank's activate was granted.
- R3: An activate is granted only once at least TRRD cycles have elapsed since the last granted activate on either bank.
- R4: A precharge of an open bank is granted only once at least TRAS_MIN cycles have elapsed since its activate. Precharge-all (`req_ap`=1) waits for every open bank. A precharge of a bank that is not open is granted at once and changes nothing.
- R5: `ras_warn[b]` is high while bank b is open and at least TRAS_MAX-RAS_WARN_LEAD cycles have elapsed since its activate. `ras_viol[b]` is high while it is open and at least TRAS_MAX cycles have elapsed. The counters saturate, so both flags stay high, without wrapping, until the precharge is granted. Both flags drop in the cycle after that grant.
- R6: After a precharge is granted, the bank is idle again, and may be activated, only once at least TRP cycles have elapsed.
- R7: Mode-register set, refresh, power-down entry (`req_cke_drop`=1 with no-operation or deselect) and self-refresh entry (`req_cke_drop`=1 with refresh) are granted only when both banks are idle.
- R8: `req_err` is raised, and the request is not granted, for a read or write to a bank that is not open, for an activate to an open bank, and for `req_cke_drop`=1 combined with any command other than no-operation, deselect or refresh.
- R9: While a valid request is not granted, the memory pins show a deselect (cs_n=1, cke drop 0). In a granted cycle the memory pins equal the request pins, bank and precharge-all bit.
- R10: After reset both banks are idle, all flags are low and every timer counts as already satisfied, so a first activate is granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A command is being requested |
| req_cs_n | input | 1 | Requested chip select, active low |
| req_ras_n | input | 1 | Requested row strobe, active low |
| req_cas_n | input | 1 | Requested column strobe, active low |
| req_we_n | input | 1 | Requested write enable, active low |
| req_ap | input | 1 | Precharge-all select |
| req_ba | input | 1 | Target bank |
| req_cke_drop | input | 1 | Request to lower clock enable (power-down or self-refresh entry) |
| req_ready | output | 1 | Command granted this cycle |
| req_err | output | 1 | Command refused as illegal for the bank state |
| mem_cs_n | output | 1 | Chip select to memory |
| mem_ras_n | output | 1 | Row strobe to memory |
| mem_cas_n | output | 1 | Column strobe to memory |
| mem_we_n | output | 1 | Write enable to memory |
| mem_ap | output | 1 | Precharge-all bit to memory |
| mem_ba | output | 1 | Bank address to memory |
| mem_cke_drop | output | 1 | Clock-enable drop to memory |
| ras_warn | output | 2 | Per-bank open-time warning |
| ras_viol | output | 2 | Per-bank open-time maximum reached |

## Verification
The hardest state to reach is one where two limits overlap on different banks. An example is a precharge-all issued while one bank has just opened and the other has been open for a long time. The wait must then follow the younger bank, and any later global command must also wait out the recovery of both. The bench gets there by sweeping the gap between two activates, issuing precharge-all in the very next cycle, and then asking at once for a mode-register set, so that each wait can be predicted from the gap alone. The saturation corner is reached by keeping one bank open for more cycles than its counter can represent and checking both flags in every one of those cycles.

// File: rtl/sdr_guard_pkg.sv
`timescale 1ns/1ps
package sdr_guard_pkg;

    localparam int NUM_BANKS = 2;

    typedef enum logic [3:0] {
        CMD_NOP,
        CMD_BST,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_MRS,
        CMD_REF,
        CMD_PDN,
        CMD_SREF,
        CMD_BAD
    } guard_cmd_e;

    typedef enum logic [1:0] {
        BANK_IDLE,
        BANK_OPEN,
        BANK_SHUT
    } bank_state_e;

endpackage

// File: rtl/sdr_guard_decode.sv
`timescale 1ns/1ps
module sdr_guard_decode
    import sdr_guard_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke_drop,
    output guard_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (cs_n) begin
            cmd = cke_drop ? CMD_PDN : CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = cke_drop ? CMD_PDN  : CMD_NOP;
                3'b001:  cmd = cke_drop ? CMD_SREF : CMD_REF;
                3'b110:  cmd = cke_drop ? CMD_BAD  : CMD_BST;
                3'b011:  cmd = cke_drop ? CMD_BAD  : CMD_ACT;
                3'b101:  cmd = cke_drop ? CMD_BAD  : CMD_RD;
                3'b100:  cmd = cke_drop ? CMD_BAD  : CMD_WR;
                3'b010:  cmd = cke_drop ? CMD_BAD  : CMD_PRE;
                3'b000:  cmd = cke_drop ? CMD_BAD  : CMD_MRS;
                default: cmd = CMD_BAD;
            endcase
        end
    end

endmodule

// File: rtl/sdr_guard_bank.sv
`timescale 1ns/1ps
module sdr_guard_bank
    import sdr_guard_pkg::*;
#(
    parameter int TRCD          = 3,
    parameter int TRAS_MIN      = 7,
    parameter int TRAS_MAX      = 5000,
    parameter int RAS_WARN_LEAD = 64,
    parameter int TRP           = 3,
    parameter int CNT_W         = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic pre_go,
    output logic ready_idle,
    output logic is_open,
    output logic rcd_ok,
    output logic pre_ok,
    output logic ras_warn,
    output logic ras_viol
);

    localparam logic [CNT_W-1:0] L_TRCD    = CNT_W'(TRCD);
    localparam logic [CNT_W-1:0] L_RASMIN  = CNT_W'(TRAS_MIN);
    localparam logic [CNT_W-1:0] L_RASMAX  = CNT_W'(TRAS_MAX);
    localparam logic [CNT_W-1:0] L_WARN_AT = CNT_W'(TRAS_MAX - RAS_WARN_LEAD);
    localparam logic [CNT_W-1:0] L_TRP     = CNT_W'(TRP);
    localparam logic [CNT_W-1:0] L_SAT     = '1;

    typedef struct packed {
        bank_state_e      st;
        logic [CNT_W-1:0] cnt;
    } bank_reg_t;

    bank_reg_t bank_d, bank_q;
    logic      shut_done;

    assign shut_done = (bank_q.st == BANK_SHUT) && (bank_q.cnt >= L_TRP);

    always_comb begin
        bank_d = bank_q;
        if (bank_q.cnt != L_SAT) begin
            bank_d.cnt = bank_q.cnt + 1'b1;
        end
        if (shut_done) begin
            bank_d.st = BANK_IDLE;
        end
        if (act_go) begin
            bank_d.st  = BANK_OPEN;
            bank_d.cnt = CNT_W'(1);
        end else if (pre_go) begin
            bank_d.st  = BANK_SHUT;
            bank_d.cnt = CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.st  <= BANK_IDLE;
            bank_q.cnt <= L_SAT;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign is_open    = (bank_q.st == BANK_OPEN);
    assign ready_idle = (bank_q.st == BANK_IDLE) || shut_done;
    assign rcd_ok     = is_open && (bank_q.cnt >= L_TRCD);
    assign pre_ok     = !is_open || (bank_q.cnt >= L_RASMIN);
    assign ras_warn   = is_open && (bank_q.cnt >= L_WARN_AT);
    assign ras_viol   = is_open && (bank_q.cnt >= L_RASMAX);

endmodule

// File: rtl/sdr_timing_guard.sv
`timescale 1ns/1ps
module sdr_timing_guard
    import sdr_guard_pkg::*;
#(
    parameter int TRCD          = 3,
    parameter int TRRD          = 2,
    parameter int TRAS_MIN      = 7,
    parameter int TRAS_MAX      = 5000,
    parameter int RAS_WARN_LEAD = 64,
    parameter int TRP           = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_cs_n,
    input  logic       req_ras_n,
    input  logic       req_cas_n,
    input  logic       req_we_n,
    input  logic       req_ap,
    input  logic       req_ba,
    input  logic       req_cke_drop,
    output logic       req_ready,
    output logic       req_err,
    output logic       mem_cs_n,
    output logic       mem_ras_n,
    output logic       mem_cas_n,
    output logic       mem_we_n,
    output logic       mem_ap,
    output logic       mem_ba,
    output logic       mem_cke_drop,
    output logic [1:0] ras_warn,
    output logic [1:0] ras_viol
);

    localparam int               CNT_W  = $clog2(TRAS_MAX + 2);
    localparam logic [CNT_W-1:0] L_TRRD = CNT_W'(TRRD);
    localparam logic [CNT_W-1:0] L_SAT  = '1;

    typedef struct packed {
        logic [CNT_W-1:0] rrd_cnt;
    } guard_reg_t;

    guard_reg_t           gd_d, gd_q;
    guard_cmd_e           cmd;
    logic [NUM_BANKS-1:0] bank_idle;
    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] bank_rcd_ok;
    logic [NUM_BANKS-1:0] bank_pre_ok;
    logic [NUM_BANKS-1:0] act_go;
    logic [NUM_BANKS-1:0] pre_go;
    logic                 rrd_ok;
    logic                 allow;
    logic                 refuse;

    sdr_guard_decode u_decode (
        .cs_n     (req_cs_n),
        .ras_n    (req_ras_n),
        .cas_n    (req_cas_n),
        .we_n     (req_we_n),
        .cke_drop (req_cke_drop),
        .cmd      (cmd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic BANK_ID = 1'(b);

        assign act_go[b] = req_ready && (cmd == CMD_ACT) && (req_ba == BANK_ID);
        assign pre_go[b] = req_ready && (cmd == CMD_PRE) && bank_open[b] &&
                           (req_ap || (req_ba == BANK_ID));

        sdr_guard_bank #(
            .TRCD          (TRCD),
            .TRAS_MIN      (TRAS_MIN),
            .TRAS_MAX      (TRAS_MAX),
            .RAS_WARN_LEAD (RAS_WARN_LEAD),
            .TRP           (TRP),
            .CNT_W         (CNT_W)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_go     (act_go[b]),
            .pre_go     (pre_go[b]),
            .ready_idle (bank_idle[b]),
            .is_open    (bank_open[b]),
            .rcd_ok     (bank_rcd_ok[b]),
            .pre_ok     (bank_pre_ok[b]),
            .ras_warn   (ras_warn[b]),
            .ras_viol   (ras_viol[b])
        );
    end

    assign rrd_ok = (gd_q.rrd_cnt >= L_TRRD);

    // grant decision for the presented command
    always_comb begin
        allow  = 1'b0;
        refuse = 1'b0;
        case (cmd)
            CMD_NOP, CMD_BST: allow = 1'b1;
            CMD_ACT: begin
                if (bank_open[req_ba]) refuse = 1'b1;
                else                   allow  = bank_idle[req_ba] && rrd_ok;
            end
            CMD_RD, CMD_WR: begin
                if (!bank_open[req_ba]) refuse = 1'b1;
                else                    allow  = bank_rcd_ok[req_ba];
            end
            CMD_PRE: allow = req_ap ? (&bank_pre_ok) : bank_pre_ok[req_ba];
            CMD_MRS, CMD_REF, CMD_PDN, CMD_SREF: allow = &bank_idle;
            default: refuse = 1'b1;
        endcase
    end

    assign req_ready = req_valid && allow && !refuse;
    assign req_err   = req_valid && refuse;

    always_comb begin
        gd_d = gd_q;
        if (gd_q.rrd_cnt != L_SAT) begin
            gd_d.rrd_cnt = gd_q.rrd_cnt + 1'b1;
        end
        if (|act_go) begin
            gd_d.rrd_cnt = CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gd_q.rrd_cnt <= L_SAT;
        end else begin
            gd_q <= gd_d;
        end
    end

    assign mem_cs_n     = req_ready ? req_cs_n     : 1'b1;
    assign mem_ras_n    = req_ready ? req_ras_n    : 1'b1;
    assign mem_cas_n    = req_ready ? req_cas_n    : 1'b1;
    assign mem_we_n     = req_ready ? req_we_n     : 1'b1;
    assign mem_ap       = req_ready ? req_ap       : 1'b0;
    assign mem_ba       = req_ready ? req_ba       : 1'b0;
    assign mem_cke_drop = req_ready ? req_cke_drop : 1'b0;

endmodule

// File: rtl/sdr_timing_guard_chk.sv
`timescale 1ns/1ps
module sdr_timing_guard_chk #(
    parameter int TRCD          = 3,
    parameter int TRRD          = 2,
    parameter int TRAS_MIN      = 7,
    parameter int TRAS_MAX      = 5000,
    parameter int RAS_WARN_LEAD = 64,
    parameter int TRP           = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_err,
    input logic       mem_cs_n,
    input logic       mem_ras_n,
    input logic       mem_cas_n,
    input logic       mem_we_n,
    input logic       mem_ap,
    input logic       mem_ba,
    input logic       mem_cke_drop,
    input logic [1:0] ras_warn,
    input logic [1:0] ras_viol
);

    logic [2:0]  pins;
    logic        m_act, m_rw, m_pre, m_glob;
    logic [1:0]  open_c;
    logic [15:0] since_c [2];
    logic [15:0] since_any;

    assign pins   = {mem_ras_n, mem_cas_n, mem_we_n};
    assign m_act  = !mem_cs_n && (pins == 3'b011);
    assign m_rw   = !mem_cs_n && (pins == 3'b101 || pins == 3'b100);
    assign m_pre  = !mem_cs_n && (pins == 3'b010);
    assign m_glob = mem_cke_drop || (!mem_cs_n && (pins == 3'b000 || pins == 3'b001));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_c    <= '0;
            since_any <= '1;
            for (int b = 0; b < 2; b++) since_c[b] <= '1;
        end else begin
            if (m_act)                   since_any <= 16'd1;
            else if (since_any != '1)    since_any <= since_any + 16'd1;
            for (int b = 0; b < 2; b++) begin
                if (m_act && mem_ba == 1'(b)) begin
                    open_c[b]  <= 1'b1;
                    since_c[b] <= 16'd1;
                end else if (m_pre && (mem_ap || mem_ba == 1'(b)) && open_c[b]) begin
                    open_c[b]  <= 1'b0;
                    since_c[b] <= 16'd1;
                end else if (since_c[b] != '1) begin
                    since_c[b] <= since_c[b] + 16'd1;
                end
            end
        end
    end

    a_r2_rcd_met: assert property (@(posedge clk) disable iff (!rst_n)
        m_rw |-> since_c[mem_ba] >= 16'(TRCD));
    a_r3_rrd_met: assert property (@(posedge clk) disable iff (!rst_n)
        m_act |-> since_any >= 16'(TRRD));
    a_r4_ras_min_met: assert property (@(posedge clk) disable iff (!rst_n)
        (m_pre && !mem_ap && open_c[mem_ba]) |-> since_c[mem_ba] >= 16'(TRAS_MIN));
    a_r4_pre_all_met: assert property (@(posedge clk) disable iff (!rst_n)
        (m_pre && mem_ap) |-> ((!open_c[0] || since_c[0] >= 16'(TRAS_MIN)) &&
                               (!open_c[1] || since_c[1] >= 16'(TRAS_MIN))));
    a_r5_warn_b0: assert property (@(posedge clk) disable iff (!rst_n)
        ras_warn[0] == (open_c[0] && since_c[0] >= 16'(TRAS_MAX - RAS_WARN_LEAD)));
    a_r5_warn_b1: assert property (@(posedge clk) disable iff (!rst_n)
        ras_warn[1] == (open_c[1] && since_c[1] >= 16'(TRAS_MAX - RAS_WARN_LEAD)));
    a_r5_viol_b0: assert property (@(posedge clk) disable iff (!rst_n)
        ras_viol[0] == (open_c[0] && since_c[0] >= 16'(TRAS_MAX)));
    a_r5_viol_b1: assert property (@(posedge clk) disable iff (!rst_n)
        ras_viol[1] == (open_c[1] && since_c[1] >= 16'(TRAS_MAX)));
    a_r6_trp_met: assert property (@(posedge clk) disable iff (!rst_n)
        m_act |-> (!open_c[mem_ba] && since_c[mem_ba] >= 16'(TRP)));
    a_r7_global_idle: assert property (@(posedge clk) disable iff (!rst_n)
        m_glob |-> (open_c == 2'b00 && since_c[0] >= 16'(TRP) && since_c[1] >= 16'(TRP)));
    a_r8_rw_open_only: assert property (@(posedge clk) disable iff (!rst_n)
        m_rw |-> open_c[mem_ba]);
    a_r8_err_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !req_ready);
    a_r9_deselect_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (mem_cs_n && !mem_cke_drop));
    a_r9_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready || req_err) |-> req_valid);

endmodule

bind sdr_timing_guard sdr_timing_guard_chk #(
    .TRCD          (TRCD),
    .TRRD          (TRRD),
    .TRAS_MIN      (TRAS_MIN),
    .TRAS_MAX      (TRAS_MAX),
    .RAS_WARN_LEAD (RAS_WARN_LEAD),
    .TRP           (TRP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_err      (req_err),
    .mem_cs_n     (mem_cs_n),
    .mem_ras_n    (mem_ras_n),
    .mem_cas_n    (mem_cas_n),
    .mem_we_n     (mem_we_n),
    .mem_ap       (mem_ap),
    .mem_ba       (mem_ba),
    .mem_cke_drop (mem_cke_drop),
    .ras_warn     (ras_warn),
    .ras_viol     (ras_viol)
);

// File: tb/sdr_timing_guard_bench.sv
`timescale 1ns/1ps
module sdr_timing_guard_bench;

    localparam int P_TRCD = 3;
    localparam int P_TRRD = 2;
    localparam int P_RMIN = 6;
    localparam int P_RMAX = 24;
    localparam int P_LEAD = 4;
    localparam int P_TRP  = 3;

    localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010;
    localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_BST = 3'b110, C_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid, req_cs_n, req_ras_n, req_cas_n, req_we_n, req_ap, req_ba, req_cke_drop;
    logic req_ready, req_err;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ap, mem_ba, mem_cke_drop;
    logic [1:0] ras_warn, ras_viol;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sdr_timing_guard #(
        .TRCD(P_TRCD), .TRRD(P_TRRD), .TRAS_MIN(P_RMIN),
        .TRAS_MAX(P_RMAX), .RAS_WARN_LEAD(P_LEAD), .TRP(P_TRP)
    ) u_sdr_timing_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs_n(req_cs_n),
        .req_ras_n(req_ras_n), .req_cas_n(req_cas_n), .req_we_n(req_we_n),
        .req_ap(req_ap), .req_ba(req_ba), .req_cke_drop(req_cke_drop),
        .req_ready(req_ready), .req_err(req_err), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_ap(mem_ap), .mem_ba(mem_ba), .mem_cke_drop(mem_cke_drop),
        .ras_warn(ras_warn), .ras_viol(ras_viol)
    );

    function automatic int pos(input int x);
        return (x > 0) ? x : 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_idle();
        req_valid = 1'b0; req_cs_n = 1'b1; req_ras_n = 1'b1; req_cas_n = 1'b1;
        req_we_n = 1'b1; req_ap = 1'b0; req_ba = 1'b0; req_cke_drop = 1'b0;
    endtask

    task automatic drive_req(input logic cs, input logic [2:0] rcw, input logic ba,
                             input logic ap, input logic ckd);
        req_valid = 1'b1; req_cs_n = cs; {req_ras_n, req_cas_n, req_we_n} = rcw;
        req_ba = ba; req_ap = ap; req_cke_drop = ckd;
    endtask

    task automatic nops(input int n);
        repeat (n) @(posedge clk);
    endtask

    // hold a request until it is granted; return the number of refused cycles
    task automatic issue(input logic cs, input logic [2:0] rcw, input logic ba,
                         input logic ap, input logic ckd, output int waited);
        waited = 0;
        @(negedge clk);
        drive_req(cs, rcw, ba, ap, ckd);
        #5;
        while (!req_ready && waited < 300) begin
            check("R9 held request shows deselect", int'(mem_cs_n), 1);
            waited++;
            @(negedge clk);
            #5;
        end
        check("R9 request finally granted", int'(req_ready), 1);
        check("R9 granted pins pass through",
              int'({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ap, mem_ba, mem_cke_drop}),
              int'({cs, rcw, ap, ba, ckd}));
        @(posedge clk);
        #1;
        drive_idle();
    endtask

    // present a request for exactly one cycle
    task automatic probe(input logic cs, input logic [2:0] rcw, input logic ba,
                         input logic ap, input logic ckd, input int exp_rdy,
                         input int exp_err, input string tag);
        @(negedge clk);
        drive_req(cs, rcw, ba, ap, ckd);
        #5;
        check({tag, " ready"}, int'(req_ready), exp_rdy);
        check({tag, " err"}, int'(req_err), exp_err);
        @(posedge clk);
        #1;
        drive_idle();
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int w, w2, el, gp;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        #5;
        check("R10 no grant without request", int'(req_ready), 0);
        check("R10 no error after reset", int'(req_err), 0);
        check("R10 warn low after reset", int'(ras_warn), 0);
        check("R10 viol low after reset", int'(ras_viol), 0);
        check("R10 pins deselected", int'(mem_cs_n), 1);

        // R1 always-granted commands with both banks idle
        probe(1'b0, C_NOP, 1'b0, 1'b0, 1'b0, 1, 0, "R1 nop idle");
        probe(1'b0, C_BST, 1'b1, 1'b0, 1'b0, 1, 0, "R1 burst stop idle");
        probe(1'b1, C_NOP, 1'b0, 1'b0, 1'b0, 1, 0, "R1 deselect idle");

        issue(1'b0, C_ACT, 1'b0, 1'b0, 1'b0, w);
        check("R10 first activate immediate", w, 0);
        nops(P_RMIN);
        issue(1'b0, C_PRE, 1'b0, 1'b0, 1'b0, w);
        check("R4 precharge after long open", w, 0);

        // R2 / R4 / R6 sweep over bank, gap and access type
        for (int b = 0; b < 2; b++) begin
            for (int op = 0; op < 2; op++) begin
                for (int g = 0; g < 5; g++) begin
                    nops(12);
                    issue(1'b0, C_ACT, 1'(b), 1'b0, 1'b0, w);
                    check("R6 activate of idle bank immediate", w, 0);
                    nops(g);
                    issue(1'b0, (op == 0) ? C_RD : C_WR, 1'(b), 1'b0, 1'b0, w);
                    check("R2 access waits for TRCD", w, pos(P_TRCD - (g + 1)));
                    el = g + 1 + w;
                    issue(1'b0, C_PRE, 1'(b), 1'b0, 1'b0, w2);
                    check("R4 precharge waits for TRAS_MIN", w2, pos(P_RMIN - (el + 1)));
                    gp = g % 4;
                    nops(gp);
                    issue(1'b0, C_ACT, 1'(b), 1'b0, 1'b0, w);
                    check("R6 reactivate waits for TRP", w, pos(P_TRP - (gp + 1)));
                    nops(P_RMIN);
                    issue(1'b0, C_PRE, 1'(b), 1'b0, 1'b0, w);
                    check("R4 precharge after TRAS_MIN", w, 0);
                end
            end
        end

        // R3 activate spacing, then precharge-all and global commands
        for (int g = 0; g < 4; g++) begin
            nops(12);
            issue(1'b0, C_ACT, 1'b0, 1'b0, 1'b0, w);
            nops(g);
            issue(1'b0, C_ACT, 1'b1, 1'b0, 1'b0, w);
            check("R3 second bank waits for TRRD", w, pos(P_TRRD - (g + 1)));
            issue(1'b0, C_PRE, 1'b0, 1'b1, 1'b0, w);
            check("R4 precharge-all waits for youngest bank", w, P_RMIN - 1);
            issue(1'b0, C_MRS, 1'b0, 1'b0, 1'b0, w);
            check("R7 mode set waits for TRP of both", w, P_TRP - 1);
            issue(1'b0, C_REF, 1'b0, 1'b0, 1'b0, w);
            check("R7 refresh granted when idle", w, 0);
            issue(1'b0, C_NOP, 1'b0, 1'b0, 1'b1, w);
            check("R7 power-down granted when idle", w, 0);
            issue(1'b0, C_REF, 1'b0, 1'b0, 1'b1, w);
            check("R7 self refresh granted when idle", w, 0);
        end

        // R7 global commands refused while a bank is open
        nops(12);
        issue(1'b0, C_ACT, 1'b1, 1'b0, 1'b0, w);
        probe(1'b0, C_MRS, 1'b0, 1'b0, 1'b0, 0, 0, "R7 mode set with open bank");
        probe(1'b0, C_REF, 1'b0, 1'b0, 1'b0, 0, 0, "R7 refresh with open bank");
        probe(1'b1, C_NOP, 1'b0, 1'b0, 1'b1, 0, 0, "R7 power-down with open bank");
        probe(1'b0, C_REF, 1'b0, 1'b0, 1'b1, 0, 0, "R7 self refresh with open bank");
        probe(1'b0, C_NOP, 1'b0, 1'b0, 1'b0, 1, 0, "R1 nop with open bank");
        probe(1'b0, C_BST, 1'b1, 1'b0, 1'b0, 1, 0, "R1 burst stop with open bank");
        nops(P_RMIN);
        issue(1'b0, C_PRE, 1'b1, 1'b0, 1'b0, w);
        probe(1'b0, C_MRS, 1'b0, 1'b0, 1'b0, 0, 0, "R6 mode set during TRP");
        nops(P_TRP);
        issue(1'b0, C_MRS, 1'b0, 1'b0, 1'b0, w);
        check("R7 mode set after TRP", w, 0);

        // R8 refused commands
        nops(12);
        probe(1'b0, C_RD, 1'b0, 1'b0, 1'b0, 0, 1, "R8 read idle bank");
        probe(1'b0, C_WR, 1'b1, 1'b0, 1'b0, 0, 1, "R8 write idle bank");
        issue(1'b0, C_ACT, 1'b0, 1'b0, 1'b0, w);
        probe(1'b0, C_ACT, 1'b0, 1'b0, 1'b0, 0, 1, "R8 activate open bank");
        probe(1'b0, C_RD, 1'b0, 1'b0, 1'b1, 0, 1, "R8 cke drop with read");
        nops(P_RMIN);
        issue(1'b0, C_PRE, 1'b0, 1'b0, 1'b0, w);
        probe(1'b0, C_WR, 1'b0, 1'b0, 1'b0, 0, 1, "R8 write closing bank");
        probe(1'b0, C_PRE, 1'b1, 1'b0, 1'b0, 1, 0, "R4 precharge of idle bank");
        probe(1'b0, C_ACT, 1'b1, 1'b0, 1'b0, 1, 0, "R4 idle precharge left bank idle");
        probe(1'b0, C_RD, 1'b1, 1'b0, 1'b0, 0, 0, "R2 read one cycle after activate");
        nops(P_RMIN);
        issue(1'b0, C_PRE, 1'b0, 1'b1, 1'b0, w);
        check("R4 precharge-all after TRAS_MIN", w, 0);

        // R5 open-time flags, every cycle past counter wrap
        nops(12);
        issue(1'b0, C_ACT, 1'b1, 1'b0, 1'b0, w);
        for (int n = 1; n <= P_RMAX + 40; n++) begin
            @(negedge clk);
            #5;
            check("R5 warn flag bank1", int'(ras_warn[1]), (n >= P_RMAX - P_LEAD) ? 1 : 0);
            check("R5 viol flag bank1", int'(ras_viol[1]), (n >= P_RMAX) ? 1 : 0);
            check("R5 bank0 flags stay low", int'({ras_warn[0], ras_viol[0]}), 0);
        end
        issue(1'b0, C_PRE, 1'b1, 1'b0, 1'b0, w);
        check("R5 precharge of overdue bank", w, 0);
        @(negedge clk);
        #5;
        check("R5 warn clears after precharge", int'(ras_warn[1]), 0);
        check("R5 viol clears after precharge", int'(ras_viol[1]), 0);

        nops(4);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule